// File: doc/BRIEF.md
# Packed SIMD Immediate ALU

This block executes one vector-with-immediate integer instruction on a 128-bit register holding packed lanes. A 32-bit instruction word and the current contents of the source register arrive together through a valid/ready handshake. The block decodes the word, expands its 8-bit immediate as the operation requires, and applies the operation to every lane at once. The lane width is 8, 16, 32 or 64 bits. The result comes back one cycle later, together with the register index it belongs to. The register named by the instruction is both the source and the destination.

The operations are wrapping add, subtract and reverse subtract; signed and unsigned saturating add and subtract; signed and unsigned max and min; and multiply by a signed immediate. An encoding that matches none of these is flagged as illegal. For an illegal encoding the block hands back the source vector untouched, so the register is not modified.

Top module: `simd_imm_alu`

## Requirements
- R1: An instruction is recognised only when bits [31:24] equal 8'b00100101. Bits [23:22] select the lane width (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits). Bits [4:0] name the register, and this index is returned on out_dest with the result.
- R2: Add/subtract group: bits [21:19] = 3'b100 and bits [15:14] = 2'b11. The immediate is the unsigned value in bits [12:5]. It is shifted left by 8 when bit 13 is set. Opcode 3'b000 in bits [18:16] gives lane + immediate, modulo 2^width.
- R3: In the add/subtract group, opcode 3'b001 gives lane − immediate and opcode 3'b011 gives immediate − lane. Both wrap modulo 2^width.
- R4: Opcode 3'b101 (unsigned saturating add) and opcode 3'b111 (unsigned saturating subtract) clamp their results to the range 0 to 2^width−1.
- R5: Opcode 3'b100 (signed saturating add) and opcode 3'b110 (signed saturating subtract) treat the expanded immediate as a non-negative value. The result is clamped to the signed range of the lane.
- R6: Min/max group: bits [21:19] = 3'b101 and bits [15:13] = 3'b110. Opcodes 000, 001, 010 and 011 give signed max, unsigned max, signed min and unsigned min. The signed forms sign-extend the 8-bit immediate and the unsigned forms zero-extend it.
- R7: Multiply: bits [21:19] = 3'b110, opcode 000 and bits [15:13] = 3'b110. Each lane becomes the low width bits of lane × sign-extended immediate.
- R8: In the add/subtract group, a byte lane width with bit 13 set is illegal.
- R9: Any other encoding that matches none of the patterns is illegal, including unused opcodes. For an illegal encoding out_illegal is 1 and out_vec equals the source vector.
- R10: A result appears on the outputs in the cycle after the input is accepted. While out_valid is high and out_ready is low, the outputs hold steady. in_ready is high exactly when the output stage is empty or is being drained in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction and source vector are presented |
| in_ready | output | 1 | Block can accept an input this cycle |
| in_insn | input | 32 | Instruction word |
| in_vec | input | VEC_W | Source register contents |
| out_valid | output | 1 | Result is presented |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_vec | output | VEC_W | Result vector (source vector when illegal) |
| out_illegal | output | 1 | Instruction was not a legal encoding |
| out_dest | output | 5 | Register index to write back |

## Verification
The hardest case to reach is signed saturation driven by a shifted immediate. In 16-bit lanes an immediate such as 0xFF00 is larger than the lane's own signed maximum, so the correct sum or difference lies outside both the signed and the unsigned lane range. To reach it, the stimulus sweeps every opcode across all four lane widths and both shift settings. It uses immediates at the sign boundary (0x7F, 0x80, 0xFF) and source vectors whose lanes sit at the signed and unsigned extremes. A second case held at the ports is a stalled output with a new request already waiting. The bench keeps out_ready low for several cycles while a different instruction is presented, then releases it. It checks that the first result was held and that the second one was taken on the release edge.

// File: rtl/simd_imm_pkg.sv
// Shared definitions for the packed SIMD immediate ALU.
// Assumes: lane widths are the four powers of two from 8 to 64 bits.
package simd_imm_pkg;

    localparam logic [7:0] MAJOR_PREFIX = 8'b0010_0101;
    localparam int         NUM_SIZES    = 4;

    typedef enum logic [3:0] {
        OP_ADD, OP_SUB, OP_RSUB,
        OP_SQADD, OP_UQADD, OP_SQSUB, OP_UQSUB,
        OP_SMAX, OP_UMAX, OP_SMIN, OP_UMIN,
        OP_MUL
    } alu_op_e;

    typedef struct packed {
        logic       legal;
        alu_op_e    op;
        logic [1:0] size;
        logic       imm_sgn;
        logic       imm_shl;
        logic [7:0] imm;
        logic [4:0] dest;
    } dec_t;

endpackage

// File: rtl/simd_imm_decode.sv
// Instruction decoder: turns the 32-bit word into an operation, lane size,
// immediate expansion controls and a legality flag.
// Assumes: purely combinational; the caller registers the result.
module simd_imm_decode
    import simd_imm_pkg::*;
(
    input  logic [31:0] insn,
    output dec_t        dec
);

    logic       prefix_ok;
    logic [2:0] opc;

    assign prefix_ok = (insn[31:24] == MAJOR_PREFIX);
    assign opc       = insn[18:16];

    // Classify the word into one of the three groups and pick the operation.
    always_comb begin
        dec         = '0;
        dec.op      = OP_ADD;
        dec.size    = insn[23:22];
        dec.imm     = insn[12:5];
        dec.dest    = insn[4:0];
        if (prefix_ok && insn[21:19] == 3'b100 && insn[15:14] == 2'b11) begin
            dec.imm_shl = insn[13];
            dec.legal   = 1'b1;
            case (opc)
                3'b000:  dec.op = OP_ADD;
                3'b001:  dec.op = OP_SUB;
                3'b011:  dec.op = OP_RSUB;
                3'b100:  dec.op = OP_SQADD;
                3'b101:  dec.op = OP_UQADD;
                3'b110:  dec.op = OP_SQSUB;
                3'b111:  dec.op = OP_UQSUB;
                default: dec.legal = 1'b0;
            endcase
            if (insn[13] && insn[23:22] == 2'b00) begin
                dec.legal = 1'b0;
            end
        end else if (prefix_ok && insn[21:19] == 3'b101 && insn[15:13] == 3'b110) begin
            dec.legal = 1'b1;
            case (opc)
                3'b000:  begin dec.op = OP_SMAX; dec.imm_sgn = 1'b1; end
                3'b001:  dec.op = OP_UMAX;
                3'b010:  begin dec.op = OP_SMIN; dec.imm_sgn = 1'b1; end
                3'b011:  dec.op = OP_UMIN;
                default: dec.legal = 1'b0;
            endcase
        end else if (prefix_ok && insn[21:19] == 3'b110 && opc == 3'b000
                     && insn[15:13] == 3'b110) begin
            dec.legal   = 1'b1;
            dec.op      = OP_MUL;
            dec.imm_sgn = 1'b1;
        end
    end

endmodule

// File: rtl/simd_lane.sv
// One lane of width W: expands the immediate and applies the operation.
// Assumes: W is 8, 16, 32 or 64; the byte/shift combination never reaches
// a result that is kept (the decoder marks it illegal).
module simd_lane
    import simd_imm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  alu_op_e      op,
    input  logic [7:0]   imm8,
    input  logic         imm_shl,
    input  logic         imm_sgn,
    output logic [W-1:0] y
);

    localparam logic signed [W+1:0] SMAXV = {3'b000, {(W-1){1'b1}}};
    localparam logic signed [W+1:0] SMINV = {3'b111, {(W-1){1'b0}}};

    logic [15:0]           imm16;
    logic [W-1:0]          imm_e;
    logic [W:0]            uadd, usub;
    logic signed [W+1:0]   sa, si, ssum, sdif;
    logic [W-1:0]          mul_lo;

    assign imm16 = imm_shl ? {imm8, 8'h00} : {8'h00, imm8};

    // Expand the immediate: sign-extended byte or zero-extended (shifted) value.
    always_comb begin
        if (imm_sgn) imm_e = W'($signed(imm8));
        else         imm_e = W'(imm16);
    end

    assign uadd   = {1'b0, a} + {1'b0, imm_e};
    assign usub   = {1'b0, a} - {1'b0, imm_e};
    assign sa     = {{2{a[W-1]}}, a};
    assign si     = {2'b00, imm_e};
    assign ssum   = sa + si;
    assign sdif   = sa - si;
    assign mul_lo = a * imm_e;

    // Select the lane result for the decoded operation.
    always_comb begin
        case (op)
            OP_ADD:   y = uadd[W-1:0];
            OP_SUB:   y = usub[W-1:0];
            OP_RSUB:  y = imm_e - a;
            OP_UQADD: y = uadd[W] ? {W{1'b1}} : uadd[W-1:0];
            OP_UQSUB: y = usub[W] ? '0 : usub[W-1:0];
            OP_SQADD: y = (ssum > SMAXV) ? SMAXV[W-1:0] : ssum[W-1:0];
            OP_SQSUB: y = (sdif < SMINV) ? SMINV[W-1:0] : sdif[W-1:0];
            OP_SMAX:  y = ($signed(a) > $signed(imm_e)) ? a : imm_e;
            OP_SMIN:  y = ($signed(a) < $signed(imm_e)) ? a : imm_e;
            OP_UMAX:  y = (a > imm_e) ? a : imm_e;
            OP_UMIN:  y = (a < imm_e) ? a : imm_e;
            OP_MUL:   y = mul_lo;
            default:  y = a;
        endcase
    end

    // Guard the bounding properties of the unsigned saturating and max forms.
    always_comb begin
        // R4
        uqadd_floor_chk: assert (op != OP_UQADD || y >= a);
        // R6
        umax_bound_chk: assert (op != OP_UMAX || (y >= a && y >= imm_e));
    end

endmodule

// File: rtl/simd_lane_bank.sv
// A bank of VEC_W/W identical lanes covering the whole vector at one width.
// Assumes: VEC_W is a multiple of W.
module simd_lane_bank
    import simd_imm_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int W     = 8
) (
    input  logic [VEC_W-1:0] vec,
    input  alu_op_e          op,
    input  logic [7:0]       imm8,
    input  logic             imm_shl,
    input  logic             imm_sgn,
    output logic [VEC_W-1:0] res
);

    localparam int LANES = VEC_W / W;

    // One lane instance per slice of the vector.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        simd_lane #(.W(W)) u_lane (
            .a       (vec[i*W +: W]),
            .op      (op),
            .imm8    (imm8),
            .imm_shl (imm_shl),
            .imm_sgn (imm_sgn),
            .y       (res[i*W +: W])
        );
    end

endmodule

// File: rtl/simd_imm_alu.sv
// Top of the packed SIMD immediate ALU: decodes, computes every lane width
// in parallel, selects one, and registers the result behind a handshake.
// Assumes: VEC_W is a multiple of 64; synchronous active-low reset.
module simd_imm_alu
    import simd_imm_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [31:0]      in_insn,
    input  logic [VEC_W-1:0] in_vec,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [VEC_W-1:0] out_vec,
    output logic             out_illegal,
    output logic [4:0]       out_dest
);

    dec_t             dec;
    logic [VEC_W-1:0] res_by_size [NUM_SIZES];
    logic             accept;

    simd_imm_decode u_dec (
        .insn (in_insn),
        .dec  (dec)
    );

    // One lane bank per supported lane width.
    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        simd_lane_bank #(.VEC_W(VEC_W), .W(8 << g)) u_bank (
            .vec     (in_vec),
            .op      (dec.op),
            .imm8    (dec.imm),
            .imm_shl (dec.imm_shl),
            .imm_sgn (dec.imm_sgn),
            .res     (res_by_size[g])
        );
    end

    assign in_ready = !out_valid || out_ready;
    assign accept   = in_valid && in_ready;

    // Output stage: load on accept, drop valid when drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_vec     <= '0;
            out_illegal <= 1'b0;
            out_dest    <= '0;
        end else if (accept) begin
            out_valid   <= 1'b1;
            out_vec     <= dec.legal ? res_by_size[dec.size] : in_vec;
            out_illegal <= !dec.legal;
            out_dest    <= dec.dest;
        end else if (out_ready) begin
            out_valid   <= 1'b0;
        end
    end

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_vec)
                                       && $stable(out_illegal) && $stable(out_dest)));

    // R10
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);

    // R9
    illegal_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !dec.legal) |=> (out_illegal && out_vec == $past(in_vec)));

    // R8
    byte_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_insn[31:24] == MAJOR_PREFIX && in_insn[23:22] == 2'b00
         && in_insn[21:19] == 3'b100 && in_insn[15:13] == 3'b111) |=> out_illegal);

    // R1
    dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (out_dest == $past(in_insn[4:0])));

endmodule

// File: tb/sim_simd_imm_alu.sv
`timescale 1ns/1ps
module sim_simd_imm_alu;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [31:0]  in_insn = '0;
    logic [127:0] in_vec = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] out_vec;
    logic         out_illegal;
    logic [4:0]   out_dest;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;
    int  seq   = 0;

    always #4 clk = ~clk;

    simd_imm_alu #(.VEC_W(128)) u0 (
        .clk, .rst_n, .in_valid, .in_ready, .in_insn, .in_vec,
        .out_valid, .out_ready, .out_vec, .out_illegal, .out_dest
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] got, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
        end
    endtask

    function automatic logic [31:0] enc(input int kind, input logic [2:0] opc,
                                        input logic [1:0] sz, input logic sh,
                                        input logic [7:0] imm, input logic [4:0] rd);
        case (kind)
            0:       return {8'h25, sz, 3'b100, opc, 2'b11, sh, imm, rd};
            1:       return {8'h25, sz, 3'b101, opc, 3'b110, imm, rd};
            default: return {8'h25, sz, 3'b110, opc, 3'b110, imm, rd};
        endcase
    endfunction

    // Arithmetic reference built from the requirement text.
    function automatic logic [127:0] ref_calc(input logic [31:0] insn,
                                              input logic [127:0] v, output logic ill);
        int w, n, kind;
        logic [2:0] opc;
        logic [7:0] imm8;
        logic sh;
        logic [127:0] acc;
        opc  = insn[18:16];
        imm8 = insn[12:5];
        sh   = insn[13];
        w    = 8 << insn[23:22];
        n    = 128 / w;
        kind = 3;
        if (insn[31:24] == 8'h25) begin
            if (insn[21:19] == 3'b100 && insn[15:14] == 2'b11) kind = 0;
            else if (insn[21:19] == 3'b101 && insn[15:13] == 3'b110) kind = 1;
            else if (insn[21:19] == 3'b110 && insn[15:13] == 3'b110) kind = 2;
        end
        ill = (kind == 3) || (kind == 0 && (opc == 3'b010 || (sh && w == 8)))
           || (kind == 1 && opc[2]) || (kind == 2 && opc != 3'b000);
        if (ill) return v;
        acc = '0;
        for (int i = 0; i < n; i++) begin
            logic signed [65:0] a, sa, iu, is, r, mask, smax, smin;
            mask = (66'sd1 <<< w) - 66'sd1;
            a    = 66'(v >> (i * w)) & mask;
            sa   = a[w-1] ? a - (mask + 66'sd1) : a;
            iu   = (kind == 0 && sh) ? 66'(imm8) * 66'sd256 : 66'(imm8);
            is   = 66'($signed(imm8));
            smax = mask >>> 1;
            smin = -smax - 66'sd1;
            r = 0;
            if (kind == 0) begin
                case (opc)
                    3'b000: r = a + iu;
                    3'b001: r = a - iu;
                    3'b011: r = iu - a;
                    3'b100: begin r = sa + iu; if (r > smax) r = smax; end
                    3'b101: begin r = a + iu;  if (r > mask) r = mask; end
                    3'b110: begin r = sa - iu; if (r < smin) r = smin; end
                    default: r = (a < iu) ? 66'sd0 : a - iu;
                endcase
            end else if (kind == 1) begin
                case (opc)
                    3'b000:  r = (sa > is) ? sa : is;
                    3'b001:  r = (a > iu) ? a : iu;
                    3'b010:  r = (sa < is) ? sa : is;
                    default: r = (a < iu) ? a : iu;
                endcase
            end else begin
                r = a * is;
            end
            acc = acc | (128'(r & mask) << (i * w));
        end
        return acc;
    endfunction

    function automatic string req_of(input int kind, input logic [2:0] opc,
                                     input logic [1:0] sz, input logic sh);
        if (kind == 0 && sh && sz == 2'b00) return "R8";
        if (kind == 0) begin
            case (opc)
                3'b000: return "R2";
                3'b001, 3'b011: return "R3";
                3'b101, 3'b111: return "R4";
                3'b100, 3'b110: return "R5";
                default: return "R9";
            endcase
        end
        if (kind == 1) return "R6";
        return "R7";
    endfunction

    function automatic logic [127:0] vec_of(input int idx);
        case (idx)
            0: return '0;
            1: return '1;
            2: return {16{8'h80}};
            3: return {16{8'h7F}};
            4: return {2{64'h8000_7FFF_0080_FF7F}};
            default: return {32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF, 32'h7F00FF80};
        endcase
    endfunction

    function automatic logic [7:0] imm_of(input int idx);
        case (idx)
            0: return 8'h00;
            1: return 8'h01;
            2: return 8'h7F;
            3: return 8'h80;
            4: return 8'hFF;
            default: return 8'h5A;
        endcase
    endfunction

    // One transaction with out_ready high; result sampled one cycle later (R10, R1).
    task automatic run_one(input logic [31:0] insn, input logic [127:0] v, input string req);
        logic [127:0] exp;
        logic eill;
        exp = ref_calc(insn, v, eill);
        @(negedge clk);
        in_valid = 1'b1; in_insn = insn; in_vec = v; out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        total++;
        if (!(out_valid && out_illegal == eill && out_vec == exp && out_dest == insn[4:0])) begin
            bad++;
            $display("FAIL %s R1 insn=%h got valid=%0b ill=%0b dest=%0d vec=%h exp ill=%0b dest=%0d vec=%h",
                     req, insn, out_valid, out_illegal, out_dest, out_vec, eill, insn[4:0], exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [127:0] ea, eb;
        logic ei;
        logic [31:0] ia, ib;
        repeat (3) @(negedge clk);
        check(!out_valid, "R10", "reset out_valid", 128'(out_valid), 128'(0));
        check(in_ready, "R10", "reset in_ready", 128'(in_ready), 128'(1));
        rst_n = 1'b1;

        // Full sweep of legal and byte/shift encodings.
        for (int kind = 0; kind < 3; kind++) begin
            for (int o = 0; o < 8; o++) begin
                if (kind == 0 && o == 2) continue;
                if (kind == 1 && o > 3) continue;
                if (kind == 2 && o > 0) continue;
                for (int sz = 0; sz < 4; sz++) begin
                    for (int sh = 0; sh < (kind == 0 ? 2 : 1); sh++) begin
                        for (int ii = 0; ii < 6; ii++) begin
                            for (int vi = 0; vi < 6; vi++) begin
                                seq++;
                                run_one(enc(kind, 3'(o), 2'(sz), 1'(sh), imm_of(ii), 5'(seq)),
                                        vec_of(vi), req_of(kind, 3'(o), 2'(sz), 1'(sh)));
                            end
                        end
                    end
                end
            end
        end

        // R9: malformed encodings
        run_one({8'h24, 2'b01, 3'b100, 3'b000, 2'b11, 1'b0, 8'h11, 5'd3}, vec_of(5), "R9");
        run_one(enc(0, 3'b010, 2'b10, 1'b0, 8'h22, 5'd4), vec_of(5), "R9");
        for (int o = 4; o < 8; o++) run_one(enc(1, 3'(o), 2'b01, 1'b0, 8'h33, 5'(o)), vec_of(4), "R9");
        run_one(enc(2, 3'b001, 2'b10, 1'b0, 8'h05, 5'd9), vec_of(5), "R9");
        run_one({8'h25, 2'b10, 3'b110, 3'b000, 3'b111, 8'h05, 5'd10}, vec_of(5), "R9");
        run_one({8'h25, 2'b10, 3'b100, 3'b000, 2'b10, 1'b0, 8'h05, 5'd11}, vec_of(5), "R9");
        run_one({8'h25, 2'b11, 3'b111, 3'b000, 3'b110, 8'h05, 5'd12}, vec_of(5), "R9");

        // R10: backpressure with a second request waiting
        ia = enc(0, 3'b000, 2'b01, 1'b1, 8'h12, 5'd20);
        ib = enc(1, 3'b010, 2'b00, 1'b0, 8'hF0, 5'd21);
        ea = ref_calc(ia, vec_of(5), ei);
        eb = ref_calc(ib, vec_of(4), ei);
        @(negedge clk);
        in_valid = 1'b1; in_insn = ia; in_vec = vec_of(5); out_ready = 1'b0;
        @(negedge clk);
        in_insn = ib; in_vec = vec_of(4);
        check(out_valid && out_vec == ea, "R10", "first result", out_vec, ea);
        check(!in_ready, "R10", "in_ready while stalled", 128'(in_ready), 128'(0));
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(out_valid && out_vec == ea && out_dest == 5'd20, "R10", "held result", out_vec, ea);
        end
        out_ready = 1'b1;
        #1;
        check(in_ready, "R10", "in_ready when draining", 128'(in_ready), 128'(1));
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && out_vec == eb && out_dest == 5'd21, "R10", "second result", out_vec, eb);
        @(negedge clk);
        check(!out_valid, "R10", "drained", 128'(out_valid), 128'(0));

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule